// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register-side front end of an eight-line interrupt controller. A processor reaches it through one address bit, an 8-bit write bus and a registered 8-bit read bus. The block decodes the multi-word initialization sequence, whose third and fourth steps are optional. It then decodes the run-time commands: a mask load, a mode command, and an eight-way end-of-interrupt and priority-rotation group selected by the top three data bits. It holds the resulting configuration: mask, vector base, priority offset, nested, auto-EOI, rotate-on-auto-EOI and special-mask flags.

The block also owns the in-service register. An acknowledge path sets bits in it through `isr_set`, and end-of-interrupt, rotate and poll commands clear them. Priority resolution stays outside the block. An attached resolver supplies the highest-priority in-service line (`best_vld`/`best_idx`) for non-specific end-of-interrupt. It also supplies the winning requested line (`win_vld`/`win_idx`) for poll reads. The pending register is outside as well: the block reads it on `pend_in`, and `pend_clr` tells its owner which bit a poll read consumed.

Top module: `intc_cmd_decoder`

## Requirements
- R1: With `rst` high at a clock edge, the following all read zero: mask, base, priority offset, in-service register, every mode flag, `init_flush`, `pend_clr` and `rdata`. The init sequencer returns to its idle step.
- R2: A write to address 0 with data bit 4 set starts initialization. It clears the mask, base, offset, in-service register and all mode flags, including poll and read-select. It pulses `init_flush` high for exactly the one cycle after that edge, and it records bit 0 as "fourth word wanted" and bit 1 as "single mode". The sequencer then waits for the base word.
- R3: The next write to address 1 sets the vector base to data AND 0xF8. If single mode is off, the sequencer then waits for the cascade word. If single mode is on, it goes to the fourth-word step when that word is wanted, and otherwise returns to idle.
- R4: The cascade word's data changes no output. After it, the sequencer goes to the fourth-word step if that word is wanted, and otherwise returns to idle. The fourth word sets the nested flag from bit 4 and auto-EOI from bit 1, then returns the sequencer to idle.
- R5: A write to address 1 loads the mask only when the sequencer is idle. Address-1 writes during initialization leave the mask unchanged.
- R6: A write to address 0 with bit 4 clear and bit 3 set is a mode command, decoded as follows. Bit 2 set arms poll. Bit 1 set makes bit 0 the read-select (1 selects in-service, 0 selects pending); bit 1 clear leaves read-select unchanged. Bit 6 set makes bit 5 the special-mask flag; bit 6 clear leaves that flag unchanged.
- R7: A write to address 0 with bits 4 and 3 clear is a command, and its code is data[7:5]. Codes 0 and 4 set rotate-on-auto-EOI to 0 and 1 respectively.
- R8: Code 1 clears in-service bit `best_idx` when `best_vld` is high. Code 5 does the same and also sets the offset to (`best_idx`+1) mod 8. When `best_vld` is low, both codes change nothing.
- R9: The following codes use the line number in data[2:0]. Code 3 clears the in-service bit for that line. Code 7 clears the same bit and sets the offset to (data[2:0]+1) mod 8. Code 6 only sets the offset to (data[2:0]+1) mod 8. Code 2 changes nothing.
- R10: A read with poll not armed behaves as follows. At address 0 it returns the in-service register when read-select is 1, or `pend_in` when read-select is 0. At address 1 it returns the mask. `rdata` changes in the cycle after the read edge.
- R11: A read with poll armed, at either address, returns `win_idx` when `win_vld` is high. It then clears that line's in-service bit and pulses the matching one-hot bit of `pend_clr` for one cycle. When `win_vld` is low, the read returns 7. Any read disarms poll.
- R12: Each bit of `isr_set` that is high at a clock edge sets the matching in-service bit, unless initialization starts on that edge. In-service bits are never set any other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pend_in | input | 8 | Pending request register from the request logic |
| isr_set | input | 8 | Acknowledge path: in-service bits to set |
| best_vld | input | 1 | Resolver found an in-service line |
| best_idx | input | 3 | Highest-priority in-service line |
| win_vld | input | 1 | Resolver found a winning request |
| win_idx | input | 3 | Winning request line |
| pend_clr | output | 8 | One-cycle, one-hot pending clear after a poll read |
| init_flush | output | 1 | One-cycle pulse: drop interrupt output and flush pending |
| inservice | output | 8 | In-service register |
| mask | output | 8 | Interrupt mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| prio_ofs | output | 3 | Line holding the top priority |
| nested_mode | output | 1 | Nested mode flag |
| auto_eoi | output | 1 | Auto end-of-interrupt flag |
| rot_aeoi | output | 1 | Rotate-on-auto-EOI flag |
| special_mask | output | 1 | Special-mask mode flag |

## Verification
Every cycle, the assertions check the following. An init command clears the configuration and raises the flush pulse. The fourth-word step is only reachable when that word was requested. The mask holds during initialization. Any read disarms poll. `pend_clr` stays one-hot or zero, and an empty poll returns 7. In-service bits never rise without an acknowledge. The priority-set command yields the written line plus one. Only the directed scenarios can show the rest: the branch taken by each of the four single/fourth-word combinations, non-specific end-of-interrupt under a rotated offset against the bench's resolver model, the read-select and special-mask gate bits, and the one-cycle length of the flush and pending-clear pulses.

// File: rtl/icd_pkg.sv
package icd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_W4   = 2'd3
  } init_step_e;

  // address-0 write decode bits
  localparam int B_INIT    = 4;
  localparam int B_MODE    = 3;
  // init word bits
  localparam int B_NEED4   = 0;
  localparam int B_SINGLE  = 1;
  localparam int B_NESTED  = 4;
  localparam int B_AEOI    = 1;
  // mode command bits
  localparam int B_POLL    = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL    = 0;
  localparam int B_SMM_EN  = 6;
  localparam int B_SMM     = 5;

  typedef enum logic [2:0] {
    CMD_ROT_OFF  = 3'd0,
    CMD_EOI      = 3'd1,
    CMD_NOP      = 3'd2,
    CMD_SEOI     = 3'd3,
    CMD_ROT_ON   = 3'd4,
    CMD_EOI_ROT  = 3'd5,
    CMD_SET_PRI  = 3'd6,
    CMD_SEOI_ROT = 3'd7
  } cmd_e;
endpackage

// File: rtl/icd_init_seq.sv
module icd_init_seq
  import icd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          init_go,
  output logic          init_flush,
  output logic [NL-1:0] mask_q,
  output logic [DW-1:0] base_q,
  output logic          nested_q,
  output logic          aeoi_q
);
  init_step_e step_q;
  logic       need4_q;
  logic       single_q;
  logic       dat_wr;

  assign init_go = wr_en && !addr && wdata[B_INIT];
  assign dat_wr  = wr_en && addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= ST_IDLE;
      need4_q    <= 1'b0;
      single_q   <= 1'b0;
      mask_q     <= '0;
      base_q     <= '0;
      nested_q   <= 1'b0;
      aeoi_q     <= 1'b0;
      init_flush <= 1'b0;
    end else begin
      init_flush <= init_go;
      if (init_go) begin
        step_q   <= ST_BASE;
        need4_q  <= wdata[B_NEED4];
        single_q <= wdata[B_SINGLE];
        mask_q   <= '0;
        base_q   <= '0;
        nested_q <= 1'b0;
        aeoi_q   <= 1'b0;
      end else if (dat_wr) begin
        unique case (step_q)
          ST_IDLE: mask_q <= wdata[NL-1:0];
          ST_BASE: begin
            base_q <= {wdata[DW-1:IW], {IW{1'b0}}};
            if (!single_q)    step_q <= ST_CASC;
            else if (need4_q) step_q <= ST_W4;
            else              step_q <= ST_IDLE;
          end
          ST_CASC: step_q <= need4_q ? ST_W4 : ST_IDLE;
          ST_W4: begin
            nested_q <= wdata[B_NESTED];
            aeoi_q   <= wdata[B_AEOI];
            step_q   <= ST_IDLE;
          end
          default: step_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_init_enter_R2: assert property (@(posedge clk) disable iff (rst)
    init_go |=> (init_flush && mask_q == '0 && base_q == '0 && !nested_q && !aeoi_q && step_q == ST_BASE));

  assert_w4_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_W4) |-> need4_q);

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (step_q != ST_IDLE && !init_go) |=> $stable(mask_q));
endmodule

// File: rtl/icd_cmd_exec.sv
module icd_cmd_exec
  import icd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          init_go,
  input  logic [NL-1:0] isr_set,
  input  logic [NL-1:0] poll_clr,
  input  logic          best_vld,
  input  logic [IW-1:0] best_idx,
  output logic [NL-1:0] isr_q,
  output logic [IW-1:0] ofs_q,
  output logic          rot_q,
  output logic          poll_q,
  output logic          rsel_q,
  output logic          smm_q
);
  logic          cmd_wr;
  logic          mode_wr;
  cmd_e          code;
  logic [IW-1:0] sel;
  logic [NL-1:0] eoi_clr;
  logic [IW-1:0] ofs_n;
  logic          rot_n;

  assign cmd_wr  = wr_en && !addr && !wdata[B_INIT] && !wdata[B_MODE];
  assign mode_wr = wr_en && !addr && !wdata[B_INIT] &&  wdata[B_MODE];
  assign code    = cmd_e'(wdata[DW-1:DW-3]);
  assign sel     = wdata[IW-1:0];

  always_comb begin
    eoi_clr = '0;
    ofs_n   = ofs_q;
    rot_n   = rot_q;
    if (cmd_wr) begin
      unique case (code)
        CMD_ROT_OFF, CMD_ROT_ON: rot_n = code[2];
        CMD_EOI, CMD_EOI_ROT: begin
          if (best_vld) begin
            eoi_clr[best_idx] = 1'b1;
            if (code == CMD_EOI_ROT) ofs_n = best_idx + 1'b1;
          end
        end
        CMD_SEOI: eoi_clr[sel] = 1'b1;
        CMD_SET_PRI: ofs_n = sel + 1'b1;
        CMD_SEOI_ROT: begin
          eoi_clr[sel] = 1'b1;
          ofs_n        = sel + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init_go) begin
      isr_q  <= '0;
      ofs_q  <= '0;
      rot_q  <= 1'b0;
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      smm_q  <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr & ~poll_clr) | isr_set;
      ofs_q <= ofs_n;
      rot_q <= rot_n;
      if (mode_wr && wdata[B_POLL]) poll_q <= 1'b1;
      else if (rd_en)               poll_q <= 1'b0;
      if (mode_wr && wdata[B_RSEL_EN]) rsel_q <= wdata[B_RSEL];
      if (mode_wr && wdata[B_SMM_EN])  smm_q  <= wdata[B_SMM];
    end
  end

  assert_poll_disarm_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> !poll_q);

  assert_isr_rise_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((isr_q & ~$past(isr_q) & ~$past(isr_set)) == '0));

  assert_setpri_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && code == CMD_SET_PRI) |=> (ofs_q == IW'($past(wdata[IW-1:0]) + 1'b1)));
endmodule

// File: rtl/icd_read_port.sv
module icd_read_port #(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          addr,
  input  logic          poll_q,
  input  logic          rsel_q,
  input  logic [NL-1:0] isr_q,
  input  logic [NL-1:0] pend_in,
  input  logic [NL-1:0] mask_q,
  input  logic          win_vld,
  input  logic [IW-1:0] win_idx,
  output logic [NL-1:0] poll_clr,
  output logic [NL-1:0] pend_clr,
  output logic [DW-1:0] rdata
);
  logic poll_hit;

  assign poll_hit = rd_en && poll_q && win_vld;

  always_comb begin
    poll_clr = '0;
    if (poll_hit) poll_clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      pend_clr <= '0;
    end else begin
      pend_clr <= poll_clr;
      if (rd_en) begin
        if (poll_q)     rdata <= win_vld ? DW'(win_idx) : DW'(NL - 1);
        else if (!addr) rdata <= rsel_q ? DW'(isr_q) : DW'(pend_in);
        else            rdata <= DW'(mask_q);
      end
    end
  end

  assert_pclr_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_clr));

  assert_poll_empty_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_q && !win_vld) |=> (rdata == DW'(NL - 1)));
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder #(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] pend_in,
  input  logic [NL-1:0] isr_set,
  input  logic          best_vld,
  input  logic [IW-1:0] best_idx,
  input  logic          win_vld,
  input  logic [IW-1:0] win_idx,
  output logic [NL-1:0] pend_clr,
  output logic          init_flush,
  output logic [NL-1:0] inservice,
  output logic [NL-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic [IW-1:0] prio_ofs,
  output logic          nested_mode,
  output logic          auto_eoi,
  output logic          rot_aeoi,
  output logic          special_mask
);
  logic          init_go;
  logic          poll_q;
  logic          rsel_q;
  logic [NL-1:0] poll_clr;

  icd_init_seq #(.DW(DW), .NL(NL)) u_init (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .init_go    (init_go),
    .init_flush (init_flush),
    .mask_q     (mask),
    .base_q     (vec_base),
    .nested_q   (nested_mode),
    .aeoi_q     (auto_eoi)
  );

  icd_cmd_exec #(.DW(DW), .NL(NL)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .init_go  (init_go),
    .isr_set  (isr_set),
    .poll_clr (poll_clr),
    .best_vld (best_vld),
    .best_idx (best_idx),
    .isr_q    (inservice),
    .ofs_q    (prio_ofs),
    .rot_q    (rot_aeoi),
    .poll_q   (poll_q),
    .rsel_q   (rsel_q),
    .smm_q    (special_mask)
  );

  icd_read_port #(.DW(DW), .NL(NL)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .poll_q   (poll_q),
    .rsel_q   (rsel_q),
    .isr_q    (inservice),
    .pend_in  (pend_in),
    .mask_q   (mask),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .poll_clr (poll_clr),
    .pend_clr (pend_clr),
    .rdata    (rdata)
  );
endmodule

// File: tb/intc_cmd_decoder_test.sv
module intc_cmd_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, pend_in = '0, isr_set = '0;
  logic       best_vld, win_vld = 1'b0;
  logic [2:0] best_idx, win_idx = '0;
  logic [7:0] rdata, pend_clr, inservice, mask, vec_base;
  logic [2:0] prio_ofs;
  logic       init_flush, nested_mode, auto_eoi, rot_aeoi, special_mask;
  int         checks = 0, errors = 0;
  logic       last_flush;
  logic [7:0] last_pclr;
  logic [7:0] rv;
  logic [2:0] ln;

  always #4 clk = ~clk;

  intc_cmd_decoder uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pend_in(pend_in), .isr_set(isr_set),
    .best_vld(best_vld), .best_idx(best_idx), .win_vld(win_vld),
    .win_idx(win_idx), .pend_clr(pend_clr), .init_flush(init_flush),
    .inservice(inservice), .mask(mask), .vec_base(vec_base),
    .prio_ofs(prio_ofs), .nested_mode(nested_mode), .auto_eoi(auto_eoi),
    .rot_aeoi(rot_aeoi), .special_mask(special_mask)
  );

  // resolver model: lowest priority number counted from the offset line
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    ln       = '0;
    for (int p = 7; p >= 0; p--) begin
      ln = prio_ofs + 3'(p);
      if (inservice[ln]) begin
        best_vld = 1'b1;
        best_idx = ln;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_flush = init_flush;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
    last_pclr = pend_clr;
  endtask

  task automatic ack(input logic [7:0] v);
    @(negedge clk);
    isr_set = v;
    @(negedge clk);
    isr_set = '0;
  endtask

  task automatic t_reset;
    chk("R1 mask", mask, 0);
    chk("R1 base", vec_base, 0);
    chk("R1 ofs", prio_ofs, 0);
    chk("R1 isr", inservice, 0);
    chk("R1 flags", {nested_mode, auto_eoi, rot_aeoi, special_mask, init_flush}, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 pend_clr", pend_clr, 0);
  endtask

  task automatic t_init_full;
    wr(0, 8'h11);
    chk("R2 flush pulse", last_flush, 1);
    @(negedge clk);
    chk("R2 flush one cycle", init_flush, 0);
    wr(1, 8'h6B);
    chk("R3 base masked", vec_base, 8'h68);
    chk("R5 mask held at base", mask, 0);
    wr(1, 8'h55);
    chk("R4 cascade word ignored", {mask, nested_mode, auto_eoi}, 0);
    wr(1, 8'h12);
    chk("R4 fourth word flags", {nested_mode, auto_eoi}, 2'b11);
    chk("R5 mask held at w4", mask, 0);
    wr(1, 8'hA5);
    chk("R5 mask load idle", mask, 8'hA5);
  endtask

  task automatic t_init_single;
    wr(0, 8'h12);
    chk("R2 clears mask", mask, 0);
    chk("R2 clears nested", {nested_mode, auto_eoi}, 0);
    wr(1, 8'h20);
    chk("R3 single base", vec_base, 8'h20);
    wr(1, 8'h3C);
    chk("R3 single no w4 to idle", mask, 8'h3C);
  endtask

  task automatic t_init_single4;
    wr(0, 8'h13);
    wr(1, 8'h40);
    wr(1, 8'h10);
    chk("R3 single to w4 flags", {nested_mode, auto_eoi}, 2'b10);
    chk("R3 single w4 mask held", mask, 0);
    wr(1, 8'h81);
    chk("R4 back to idle", mask, 8'h81);
  endtask

  task automatic t_init_casc_only;
    wr(0, 8'h10);
    wr(1, 8'h08);
    wr(1, 8'h77);
    chk("R4 cascade no w4 mask", mask, 0);
    wr(1, 8'h99);
    chk("R4 cascade then idle", mask, 8'h99);
    chk("R4 flags untouched", {nested_mode, auto_eoi}, 0);
  endtask

  task automatic t_mode;
    wr(0, 8'h68);
    chk("R6 smm set", special_mask, 1);
    wr(0, 8'h28);
    chk("R6 smm gate clear", special_mask, 1);
    wr(0, 8'h48);
    chk("R6 smm clear", special_mask, 0);
    ack(8'h24);
    chk("R12 isr set", inservice, 8'h24);
    pend_in = 8'h5A;
    wr(0, 8'h0B);
    rd(0, rv);
    chk("R10 read isr", rv, 8'h24);
    wr(0, 8'h09);
    rd(0, rv);
    chk("R6 rsel gate clear", rv, 8'h24);
    wr(0, 8'h0A);
    rd(0, rv);
    chk("R10 read pending", rv, 8'h5A);
    rd(1, rv);
    chk("R10 read mask", rv, 8'h99);
  endtask

  task automatic t_rot;
    wr(0, 8'h80);
    chk("R7 rot on", rot_aeoi, 1);
    wr(0, 8'h00);
    chk("R7 rot off", rot_aeoi, 0);
  endtask

  task automatic t_eoi;
    wr(0, 8'h20);
    chk("R8 eoi clears best", inservice, 8'h20);
    wr(0, 8'hA0);
    chk("R8 rot eoi isr", inservice, 0);
    chk("R8 rot eoi ofs", prio_ofs, 6);
    wr(0, 8'h20);
    chk("R8 empty eoi isr", inservice, 0);
    chk("R8 empty eoi ofs", prio_ofs, 6);
    ack(8'h81);
    wr(0, 8'h20);
    chk("R8 eoi rotated order", inservice, 8'h01);
    wr(0, 8'h60);
    chk("R9 specific line0", inservice, 0);
  endtask

  task automatic t_specific;
    ack(8'h0C);
    wr(0, 8'h63);
    chk("R9 specific line3", inservice, 8'h04);
    wr(0, 8'hE2);
    chk("R9 specific rot isr", inservice, 0);
    chk("R9 specific rot ofs", prio_ofs, 3);
    wr(0, 8'hC5);
    chk("R9 set priority", prio_ofs, 6);
    wr(0, 8'hC7);
    chk("R9 set priority wrap", prio_ofs, 0);
    ack(8'h10);
    wr(0, 8'h44);
    chk("R9 code2 nop", {inservice, 5'(prio_ofs), rot_aeoi, special_mask}, {8'h10, 5'd0, 1'b0, 1'b0});
  endtask

  task automatic t_poll;
    wr(0, 8'h0C);
    win_vld = 1'b1; win_idx = 3'd4;
    rd(0, rv);
    chk("R11 poll winner", rv, 4);
    chk("R11 poll pend clr", last_pclr, 8'h10);
    chk("R11 poll isr clr", inservice, 0);
    @(negedge clk);
    chk("R11 pend clr one cycle", pend_clr, 0);
    rd(0, rv);
    chk("R11 poll disarmed", rv, 8'h5A);
    wr(0, 8'h0C);
    win_vld = 1'b0;
    rd(1, rv);
    chk("R11 poll empty", rv, 7);
    chk("R11 empty no clr", last_pclr, 0);
    rd(1, rv);
    chk("R11 disarmed addr1", rv, 8'h99);
  endtask

  task automatic t_init_clears;
    wr(0, 8'hC5);
    wr(0, 8'h80);
    wr(0, 8'h68);
    wr(0, 8'h0B);
    ack(8'h03);
    wr(0, 8'h13);
    chk("R2 clears config", {inservice, mask, vec_base, 5'(prio_ofs), rot_aeoi, special_mask, nested_mode},
        {8'h00, 8'h00, 8'h00, 5'd0, 3'b000});
    chk("R2 flush", last_flush, 1);
    rd(0, rv);
    chk("R2 rsel cleared", rv, 8'h5A);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_init_single();
    t_init_single4();
    t_init_casc_only();
    t_mode();
    t_rot();
    t_eoi();
    t_specific();
    t_poll();
    t_init_clears();
    report();
  end
endmodule